// File: doc/BRIEF.md
# I2C Slave With Auto-Incrementing Two-Byte Pointer

This block is an I2C target that gives an external host access to an internal register and memory space. The internal side is a 16-bit address space. The slave answers the 7-bit address 1011101. A write transaction loads a 16-bit pointer from two bytes and then stores each further byte at the pointer, moving the pointer on by one after each store. A read transaction streams bytes out starting at the pointer, and it too moves the pointer on after each byte.

The bus lines enter as raw SCL and SDA levels. Each passes through a two-flop synchronizer on the system clock, which must run at least 16 times faster than SCL. SDA is driven open-drain: while `sda_oe` is high, the line is pulled low. On the internal side there is a plain synchronous bus with one-cycle write and read strobes. Read data is expected on the cycle after the read strobe.

The controller is a state machine with six states:
- **IDLE** waits for a start condition.
- **RX** shifts in a byte on rising SCL edges.
- **ACK** drives the acknowledge bit.
- **TX** shifts a byte out on falling SCL edges.
- **MACK** samples the host's acknowledge.
- **RD_WAIT** holds until the next falling edge.

The transitions are:
- A stop condition sends any state to IDLE.
- A start condition sends any state to RX, with the byte kind reset to "device address".
- RX goes to ACK when a received byte completes on a falling edge, or to IDLE if that byte is a non-matching device address.
- ACK goes to TX after a matching read address, and to RX otherwise.
- TX goes to MACK after the eighth bit.
- MACK goes to IDLE on a host NACK, or to RD_WAIT on a host ACK.
- RD_WAIT goes to TX on the next falling edge.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The slave acknowledges only address bytes whose upper seven bits are 1011101 (0xBA for write, 0xBB for read). For any other address it leaves SDA released during the acknowledge bit and for the rest of that transaction. It does not acknowledge or store any later byte until the next start condition.
- R2: In a write transaction, the two bytes after the address byte load the pointer, high byte first. The slave acknowledges each of these bytes.
- R3: Each data byte of a write transaction produces a single-cycle `bus_we` with `bus_addr` equal to the pointer and `bus_wdata` equal to the byte. The pointer then increments as a full 16-bit value, so 0x12FF is followed by 0x1300.
- R4: Bytes are shifted most significant bit first in both directions.
- R5: After a 0xBB address byte, the slave issues one `bus_re` per byte it sends, at the pointer, and then increments the pointer. It captures `bus_rdata` on the cycle after the strobe.
- R6: When the host answers a byte with NACK, the slave releases SDA, issues no further read strobe and returns to IDLE. The pointer is left at the address after the last byte sent.
- R7: A start condition or a stop condition resets the bit and byte counters but keeps the pointer. This lets a read transaction continue from where an earlier one left off, and lets a repeated start join a pointer setup to a read.
- R8: `sda_oe` changes only while the synchronized SCL is low.
- R9: `bus_we` and `bus_re` are never high together, and each is high for only one cycle at a time.
- R10: After reset, `sda_oe`, `bus_we` and `bus_re` are low and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| bus_addr | output | 16 | Internal access address |
| bus_wdata | output | 8 | Internal write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_rdata | input | 8 | Internal read data, valid the cycle after `bus_re` |
| bus_re | output | 1 | One-cycle read strobe |

## Verification
The bound checker watches on every cycle that the SDA drive changes only while SCL is low, and that the strobes stay exclusive and one cycle long. It also checks that SDA is released right after every start or stop condition.

Some behaviour needs whole transactions, so only the bench scenarios can show it:
- address matching over the full 7-bit space;
- the order of the pointer bytes and the carry across the low byte;
- bit order in both directions;
- the point at which reading stops after a NACK;
- keeping the pointer across stops and repeated starts.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_RD_WAIT
    } slv_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_PTR,
        K_DATA
    } rx_kind_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b1011101,
    parameter int         PTR_BYTES   = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe,
    output logic [PTR_BYTES*BYTE_BITS-1:0] bus_addr,
    output logic [BYTE_BITS-1:0]          bus_wdata,
    output logic                          bus_we,
    input  logic [BYTE_BITS-1:0]          bus_rdata,
    output logic                          bus_re
);

    localparam int ADDR_W = PTR_BYTES * BYTE_BITS;
    localparam int IDX_W  = $clog2(PTR_BYTES + 1);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS - 1);
    localparam logic [3:0] FULL_CNT = 4'(BYTE_BITS);
    localparam logic [IDX_W-1:0] PTR_DONE = IDX_W'(PTR_BYTES);

    // line synchronizers, one per bus wire
    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    assign raw_lines = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sync
            i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw_lines[g]),
                .q     (sync_lines[g])
            );
        end
    endgenerate

    logic scl_s;
    logic sda_s;
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    logic scl_rise;
    logic scl_fall;
    logic start_evt;
    logic stop_evt;

    i2c_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    slv_state_t            state;
    slv_state_t            state_nxt;
    rx_kind_t              kind;
    logic [3:0]            cnt;
    logic [BYTE_BITS-1:0]  rx_sh;
    logic [BYTE_BITS-1:0]  tx_sh;
    logic [ADDR_W-1:0]     ptr;
    logic [IDX_W-1:0]      pidx;
    logic                  rw;
    logic                  re_d;

    logic byte_done;
    logic addr_hit;
    assign byte_done = scl_fall && (cnt == FULL_CNT);
    assign addr_hit  = (rx_sh[BYTE_BITS-1:1] == SLAVE_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (stop_evt) begin
            state_nxt = ST_IDLE;
        end else if (start_evt) begin
            state_nxt = ST_RX;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_RX: begin
                    if (byte_done) begin
                        state_nxt = (kind == K_DEV && !addr_hit) ? ST_IDLE : ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_nxt = (kind == K_DEV && rw) ? ST_TX : ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall && cnt == LAST_BIT) begin
                        state_nxt = ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        state_nxt = sda_s ? ST_IDLE : ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (scl_fall) begin
                        state_nxt = ST_TX;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // datapath, counters and bus strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind      <= K_DEV;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '1;
            ptr       <= '0;
            pidx      <= '0;
            rw        <= 1'b0;
            re_d      <= 1'b0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            bus_we <= 1'b0;
            bus_re <= 1'b0;
            re_d   <= bus_re;
            if (re_d) begin
                tx_sh <= bus_rdata;
            end
            if (start_evt) begin
                cnt  <= '0;
                kind <= K_DEV;
                pidx <= '0;
                rw   <= 1'b0;
            end else if (stop_evt) begin
                cnt  <= '0;
                pidx <= '0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_BITS-2:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (byte_done) begin
                            unique case (kind)
                                K_DEV: begin
                                    if (addr_hit) begin
                                        rw <= rx_sh[0];
                                        if (rx_sh[0]) begin
                                            bus_re   <= 1'b1;
                                            bus_addr <= ptr;
                                            ptr      <= ptr + 1'b1;
                                        end
                                    end
                                end
                                K_PTR: begin
                                    ptr  <= {ptr[ADDR_W-BYTE_BITS-1:0], rx_sh};
                                    pidx <= pidx + 1'b1;
                                end
                                K_DATA: begin
                                    bus_we    <= 1'b1;
                                    bus_addr  <= ptr;
                                    bus_wdata <= rx_sh;
                                    ptr       <= ptr + 1'b1;
                                end
                                default: kind <= K_DEV;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (kind == K_DEV) begin
                                if (!rw) begin
                                    kind <= K_PTR;
                                end
                            end else if (kind == K_PTR && pidx == PTR_DONE) begin
                                kind <= K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall && cnt != LAST_BIT) begin
                            tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b1};
                            cnt   <= cnt + 4'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise && !sda_s) begin
                            bus_re   <= 1'b1;
                            bus_addr <= ptr;
                            ptr      <= ptr + 1'b1;
                        end
                    end
                    ST_RD_WAIT: begin
                        if (scl_fall) begin
                            cnt <= '0;
                        end
                    end
                    default: cnt <= cnt;
                endcase
            end
        end
    end

    // SDA drive
    always_comb begin
        unique case (state)
            ST_ACK:  sda_oe = 1'b1;
            ST_TX:   sda_oe = ~tx_sh[BYTE_BITS-1];
            default: sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic start_evt,
    input logic stop_evt,
    input logic bus_we,
    input logic bus_re
);

    // R8
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R8
    oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R9
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    // R9
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R7
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .bus_we    (bus_we),
    .bus_re    (bus_re)
);

// File: tb/test_i2c_ptr_slave.sv
module test_i2c_ptr_slave;

    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic [7:0]  bus_rdata;
    logic        bus_re;
    wire         sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_ptr_slave i_i2c_ptr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .bus_re    (bus_re)
    );

    logic [7:0]  mem [0:255];
    logic [15:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    int          wcnt = 0;
    int          recnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
            bus_rdata <= '0;
        end else begin
            if (bus_we) begin
                mem[bus_addr[7:0]] <= bus_wdata;
                if (wcnt < 16) begin
                    wlog_a[wcnt] <= bus_addr;
                    wlog_d[wcnt] <= bus_wdata;
                end
                wcnt <= wcnt + 1;
            end
            if (bus_re) begin
                bus_rdata <= mem[bus_addr[7:0]];
                recnt <= recnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic set_ptr(input logic [15:0] p, input bit do_stop);
        bit a;
        i2c_start();
        send_byte(8'hBA, a);    chk(a, "R1", a, 1);
        send_byte(p[15:8], a);  chk(a, "R2", a, 1);
        send_byte(p[7:0], a);   chk(a, "R2", a, 1);
        if (do_stop) i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit         a;
        logic [7:0] v;
        int         w0;
        int         r0;
        logic [7:0] wdat [0:3];
        wdat[0] = 8'hA5; wdat[1] = 8'h3C; wdat[2] = 8'h81; wdat[3] = 8'h7E;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R10: reset state
        chk(!sda_oe && !bus_we && !bus_re, "R10", {sda_oe, bus_we, bus_re}, 0);

        // R10 pointer starts at zero; R5 read strobe count; R6 stop on NACK
        r0 = recnt;
        i2c_start();
        send_byte(8'hBB, a);  chk(a, "R1", a, 1);
        recv_byte(v, 1'b0);
        chk(v == 8'd3, "R10", v, 3);
        chk(!sda_oe, "R6", sda_oe, 0);
        i2c_stop();
        chk(recnt - r0 == 1, "R6", recnt - r0, 1);

        // R1 sweep of every 7-bit address with R/W low
        w0 = wcnt;
        for (int ad = 0; ad < 128; ad++) begin
            i2c_start();
            send_byte({7'(ad), 1'b0}, a);
            chk(a == (ad == 7'h5D), "R1", a, (ad == 7'h5D));
            i2c_stop();
        end
        chk(wcnt == w0, "R1", wcnt - w0, 0);

        // R1 non-matching address: following bytes are ignored
        foreach (wdat[k]) begin
            i2c_start();
            send_byte((k % 2) ? 8'hBC : 8'hB8, a);
            chk(!a, "R1", a, 0);
            send_byte(8'h12, a); chk(!a, "R1", a, 0);
            send_byte(8'h34, a); chk(!a, "R1", a, 0);
            send_byte(wdat[k], a); chk(!a, "R1", a, 0);
            i2c_stop();
        end
        chk(wcnt == w0, "R1", wcnt - w0, 0);

        // R3 write burst across the low-byte carry, R4 asymmetric patterns
        w0 = wcnt;
        set_ptr(16'h12FE, 1'b0);
        foreach (wdat[k]) begin
            send_byte(wdat[k], a);
            chk(a, "R3", a, 1);
        end
        i2c_stop();
        chk(wcnt - w0 == 4, "R3", wcnt - w0, 4);
        for (int k = 0; k < 4; k++) begin
            chk(wlog_a[w0 + k] == 16'(16'h12FE + k), "R3", wlog_a[w0 + k], 16'h12FE + k);
            chk(wlog_d[w0 + k] == wdat[k], "R4", wlog_d[w0 + k], wdat[k]);
        end

        // R5 read back from the same pointer, R6 NACK ends it
        set_ptr(16'h12FE, 1'b1);
        r0 = recnt;
        i2c_start();
        send_byte(8'hBB, a); chk(a, "R1", a, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(v, k != 3);
            chk(v == wdat[k], "R5", v, wdat[k]);
        end
        chk(!sda_oe, "R6", sda_oe, 0);
        tick(4 * Q);
        chk(recnt - r0 == 4, "R6", recnt - r0, 4);
        i2c_stop();

        // R7 a new read continues after the last byte sent
        i2c_start();
        send_byte(8'hBB, a); chk(a, "R1", a, 1);
        recv_byte(v, 1'b1); chk(v == 8'(2 * 7 + 3), "R7", v, 2 * 7 + 3);
        recv_byte(v, 1'b0); chk(v == 8'(3 * 7 + 3), "R7", v, 3 * 7 + 3);
        i2c_stop();

        // R7 repeated start joins pointer setup and read
        set_ptr(16'h0010, 1'b0);
        i2c_start();
        send_byte(8'hBB, a); chk(a, "R7", a, 1);
        recv_byte(v, 1'b0); chk(v == 8'(16 * 7 + 3), "R7", v, 16 * 7 + 3);
        i2c_stop();

        // R7 pointer kept across a stop after a write
        w0 = wcnt;
        set_ptr(16'h0040, 1'b0);
        send_byte(8'h11, a); chk(a, "R3", a, 1);
        i2c_stop();
        chk(wlog_a[w0] == 16'h0040 && wlog_d[w0] == 8'h11, "R3", wlog_a[w0], 16'h0040);
        i2c_start();
        send_byte(8'hBB, a); chk(a, "R1", a, 1);
        recv_byte(v, 1'b0); chk(v == 8'(65 * 7 + 3), "R7", v, 65 * 7 + 3);
        i2c_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule